// File: doc/BRIEF.md
# Strap-Latched Configuration Register with I/O Window Decoder

This block holds one 8-bit peripheral configuration register. Software reaches it through three ports on a simplified ISA I/O bus. The first is a key port. The second is an index port. The third is a data port, which reads and writes the register while the key port holds 89h and the index port holds 00h.

At reset the upper four bits of the register load from four strap inputs. The lower four bits clear to zero. From then on the upper bits steer combinational chip-select decoding for two controllers:

- a hard-disk controller port, with an enable bit and a primary/secondary address choice;
- a floppy controller port, with an enable bit and a primary/secondary address choice. It also has a clock-enable output that switches the floppy logic off while that port is disabled.

The lower four bits are plain software storage. A write through the data port changes the decoded windows on the next cycle.

Top module: `strap_cfg_decode`

## Requirements
- R1: While `rst` is high, each clock edge loads the register with {strap_ide_off, strap_ide_hi, strap_fdc_off, strap_fdc_hi, 4'b0000}, in bit order 7 down to 4, then 3..0.
- R2: Strap inputs that change after `rst` falls leave the register unchanged.
- R3: A write of 89h to the key port (default 250h) unlocks the data port. With the index port (default 251h) holding 00h, a write to the data port (default 252h) stores `io_wdata` at the next clock edge, and a read there returns the stored value on `io_rdata`.
- R4: A write of any value other than 89h to the key port locks the data port. Reset also locks it. While locked, data-port reads return 00h and data-port writes leave the register unchanged.
- R5: While the index port holds a value other than 00h, data-port reads return 00h and data-port writes leave the register unchanged.
- R6: When bit 7 is 1, `ide_cs` stays low for every address.
- R7: When bit 7 is 0, `ide_cs` is high for an address in one of two sets and low for any other address. With bit 6 = 1 the set is 1F0h–1F7h plus 3F6h and 3F7h. With bit 6 = 0 the set is 170h–177h plus 376h and 377h.
- R8: When bit 5 is 1, `fdc_cs` and `fdc_clk_en` are both low. When bit 5 is 0, `fdc_clk_en` is high.
- R9: When bit 5 is 0, `fdc_cs` is high only for 3F0h–3F7h when bit 4 = 1, and only for 370h–377h when bit 4 = 0. The floppy and disk windows may assert together on a shared address.
- R10: Bits 3..0 read back as written and have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps sampled while high |
| strap_ide_off | input | 1 | Strap for bit 7 (1 = disk port disabled) |
| strap_ide_hi | input | 1 | Strap for bit 6 (1 = primary disk window) |
| strap_fdc_off | input | 1 | Strap for bit 5 (1 = floppy port disabled) |
| strap_fdc_hi | input | 1 | Strap for bit 4 (1 = primary floppy window) |
| io_addr | input | 10 | ISA I/O address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe, active high |
| io_wr | input | 1 | Write strobe, active high, sampled at the clock edge |
| io_rdata | output | 8 | Read data, 00h unless an unlocked data-port read |
| ide_cs | output | 1 | Disk controller chip select |
| fdc_cs | output | 1 | Floppy controller chip select |
| fdc_clk_en | output | 1 | Floppy clock enable |

## Verification
The hardest case to reach is the register contents after a second reset. The straps must differ from the first reset so that the reload is visible. The data port must stay locked through the new reset, so the decode outputs are the only early view of the register. The stimulus therefore asserts reset a second time with the opposite straps. It probes the decode windows before any unlock, and only then unlocks and reads the value back. The shared addresses 377h and 3F6h/3F7h, where both chip selects assert, are also probed so that overlapping windows are covered.

// File: rtl/strap_cfg_decode.sv
module strap_cfg_decode #(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_PORT  = 10'h250,
  parameter logic [AW-1:0] IDX_PORT  = 10'h251,
  parameter logic [AW-1:0] DATA_PORT = 10'h252,
  parameter logic [DW-1:0] KEY_VAL   = 8'h89,
  parameter logic [DW-1:0] REG_INDEX = 8'h00,
  parameter logic [AW-1:0] IDE_PRI_BASE = 10'h1F0,
  parameter logic [AW-1:0] IDE_SEC_BASE = 10'h170,
  parameter logic [AW-1:0] IDE_PRI_ALT  = 10'h3F6,
  parameter logic [AW-1:0] IDE_SEC_ALT  = 10'h376,
  parameter logic [AW-1:0] FDC_PRI_BASE = 10'h3F0,
  parameter logic [AW-1:0] FDC_SEC_BASE = 10'h370
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strap_ide_off,
  input  logic          strap_ide_hi,
  input  logic          strap_fdc_off,
  input  logic          strap_fdc_hi,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_rd,
  input  logic          io_wr,
  output logic [DW-1:0] io_rdata,
  output logic          ide_cs,
  output logic          fdc_cs,
  output logic          fdc_clk_en
);
  localparam int BLK_LSB  = 3;
  localparam int PAIR_LSB = 1;
  localparam int B_IDE_OFF = 7;
  localparam int B_IDE_HI  = 6;
  localparam int B_FDC_OFF = 5;
  localparam int B_FDC_HI  = 4;
  localparam int LOW_W     = 4;

  logic [DW-1:0] cr0;
  logic [DW-1:0] index;
  logic          unlocked;
  logic          sel;

  assign sel = unlocked && (index == REG_INDEX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cr0      <= {strap_ide_off, strap_ide_hi, strap_fdc_off, strap_fdc_hi, {LOW_W{1'b0}}};
      index    <= '0;
      unlocked <= 1'b0;
    end else if (io_wr) begin
      if (io_addr == KEY_PORT) unlocked <= (io_wdata == KEY_VAL);
      if (io_addr == IDX_PORT) index <= io_wdata;
      if (io_addr == DATA_PORT && sel) cr0 <= io_wdata;
    end
  end

  assign io_rdata = (io_rd && io_addr == DATA_PORT && sel) ? cr0 : '0;

  logic [AW-1:0] ide_base, ide_alt, fdc_base;
  assign ide_base = cr0[B_IDE_HI] ? IDE_PRI_BASE : IDE_SEC_BASE;
  assign ide_alt  = cr0[B_IDE_HI] ? IDE_PRI_ALT  : IDE_SEC_ALT;
  assign fdc_base = cr0[B_FDC_HI] ? FDC_PRI_BASE : FDC_SEC_BASE;

  logic ide_in_blk, ide_in_pair, fdc_in_blk;
  assign ide_in_blk  = io_addr[AW-1:BLK_LSB]  == ide_base[AW-1:BLK_LSB];
  assign ide_in_pair = io_addr[AW-1:PAIR_LSB] == ide_alt[AW-1:PAIR_LSB];
  assign fdc_in_blk  = io_addr[AW-1:BLK_LSB]  == fdc_base[AW-1:BLK_LSB];

  assign ide_cs     = !cr0[B_IDE_OFF] && (ide_in_blk || ide_in_pair);
  assign fdc_clk_en = !cr0[B_FDC_OFF];
  assign fdc_cs     = fdc_clk_en && fdc_in_blk;
endmodule

// File: rtl/strap_cfg_decode_chk.sv
module strap_cfg_decode_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] straps,
  input logic [7:0] cr0,
  input logic [7:0] index,
  input logic       unlocked,
  input logic [7:0] io_rdata,
  input logic       ide_cs,
  input logic       fdc_cs,
  input logic       fdc_clk_en
);
  logic       rst_q = 1'b0;
  logic [3:0] strap_q = 4'h0;

  always_ff @(posedge clk) begin
    rst_q   <= rst;
    strap_q <= straps;
  end

  always @(posedge clk)
    if (rst_q) AST_STRAP_LOAD: assert (cr0 == {strap_q, 4'h0}); // R1

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst) !unlocked |=> $stable(cr0)); // R4
  AST_LOCK_READ: assert property (@(posedge clk) disable iff (rst) !unlocked |-> io_rdata == 8'h00); // R4
  AST_INDEX_READ: assert property (@(posedge clk) disable iff (rst) (index != 8'h00) |-> io_rdata == 8'h00); // R5
  AST_IDE_OFF: assert property (@(posedge clk) disable iff (rst) cr0[7] |-> !ide_cs); // R6
  AST_FDC_OFF: assert property (@(posedge clk) disable iff (rst) cr0[5] |-> (!fdc_cs && !fdc_clk_en)); // R8
  AST_FDC_CLK: assert property (@(posedge clk) disable iff (rst) fdc_cs |-> fdc_clk_en); // R8
endmodule

bind strap_cfg_decode strap_cfg_decode_chk chk_i (
  .clk(clk), .rst(rst),
  .straps({strap_ide_off, strap_ide_hi, strap_fdc_off, strap_fdc_hi}),
  .cr0(cr0), .index(index), .unlocked(unlocked), .io_rdata(io_rdata),
  .ide_cs(ide_cs), .fdc_cs(fdc_cs), .fdc_clk_en(fdc_clk_en)
);

// File: tb/strap_cfg_decode_test.sv
module strap_cfg_decode_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] KEY = 10'h250, IDX = 10'h251, DAT = 10'h252;

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] straps = 4'h0;
  logic [9:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_rdata;
  logic ide_cs, fdc_cs, fdc_clk_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_cfg_decode uut (
    .clk(clk), .rst(rst),
    .strap_ide_off(straps[3]), .strap_ide_hi(straps[2]),
    .strap_fdc_off(straps[1]), .strap_fdc_hi(straps[0]),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
    .io_rdata(io_rdata), .ide_cs(ide_cs), .fdc_cs(fdc_cs), .fdc_clk_en(fdc_clk_en)
  );

  typedef struct {
    logic [7:0] d;
    logic ide, fdc, ce;
    string tag;
  } exp_t;

  exp_t q[$];
  logic req = 1'b0;
  logic [7:0] model;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic exp_ide(logic [7:0] m, logic [9:0] a);
    if (m[7]) return 1'b0;
    if (m[6]) return (a >= 10'h1F0 && a <= 10'h1F7) || a == 10'h3F6 || a == 10'h3F7;
    return (a >= 10'h170 && a <= 10'h177) || a == 10'h376 || a == 10'h377;
  endfunction

  function automatic logic exp_fdc(logic [7:0] m, logic [9:0] a);
    if (m[5]) return 1'b0;
    if (m[4]) return a >= 10'h3F0 && a <= 10'h3F7;
    return a >= 10'h370 && a <= 10'h377;
  endfunction

  task automatic probe(logic [9:0] a, logic rd, logic [7:0] d, string tag);
    exp_t e;
    @(posedge clk); #1;
    io_addr = a; io_rd = rd; req = 1'b1;
    e.d = d; e.ide = exp_ide(model, a); e.fdc = exp_fdc(model, a); e.ce = !model[5]; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    req = 1'b0; io_rd = 1'b0;
  endtask

  task automatic look(logic [9:0] a, string tag);
    probe(a, 1'b0, 8'h00, tag);
  endtask

  task automatic rd_cr(logic [7:0] d, string tag);
    probe(DAT, 1'b1, d, tag);
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  always @(negedge clk) begin
    if (req) begin
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual sample with no expected item, expected one queued");
      end else begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (io_rdata !== e.d || ide_cs !== e.ide || fdc_cs !== e.fdc || fdc_clk_en !== e.ce) begin
          errors++;
          $display("FAIL %s addr=%h actual rdata=%h ide=%b fdc=%b ce=%b expected rdata=%h ide=%b fdc=%b ce=%b",
                   e.tag, io_addr, io_rdata, ide_cs, fdc_cs, fdc_clk_en, e.d, e.ide, e.fdc, e.ce);
        end
      end
    end
  end

  task automatic do_reset(logic [3:0] s);
    @(posedge clk); #1;
    straps = s; rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    model = {s, 4'h0};
  endtask

  initial begin
    do_reset(4'b0101);
    look(10'h1F0, "R1 strap primary disk window");
    look(10'h3F0, "R1 strap primary floppy window");
    rd_cr(8'h00, "R4 locked after reset");
    straps = 4'b1010;
    wr(KEY, 8'h89); wr(IDX, 8'h00);
    rd_cr(8'h50, "R1 R2 R3 readback after unlock");
    look(10'h1F0, "R2 late straps ignored");

    wr(DAT, 8'h00); model = 8'h00;
    rd_cr(8'h00, "R3 write then read");
    look(10'h170, "R7 secondary low"); look(10'h177, "R7 secondary high");
    look(10'h178, "R7 past secondary"); look(10'h376, "R7 secondary pair");
    look(10'h375, "R7 below pair"); look(10'h1F0, "R7 primary unselected");
    look(10'h370, "R9 floppy secondary"); look(10'h377, "R9 R7 shared address");
    look(10'h3F0, "R9 floppy primary unselected");

    wr(DAT, 8'h50); model = 8'h50;
    look(10'h1F0, "R7 primary low"); look(10'h1F7, "R7 primary high");
    look(10'h1EF, "R7 below primary"); look(10'h3F6, "R7 R9 shared pair");
    look(10'h3F5, "R9 floppy only"); look(10'h170, "R7 secondary unselected");
    look(10'h370, "R9 secondary unselected");

    wr(DAT, 8'h5A); model = 8'h5A;
    rd_cr(8'h5A, "R10 low bits stored");
    look(10'h1F0, "R10 decode unaffected"); look(10'h3F7, "R10 decode unaffected");

    wr(DAT, 8'hD0); model = 8'hD0;
    look(10'h1F0, "R6 disk disabled"); look(10'h3F6, "R6 pair disabled");
    wr(DAT, 8'h70); model = 8'h70;
    look(10'h3F0, "R8 floppy disabled"); look(10'h1F0, "R8 disk still on");
    wr(DAT, 8'h50); model = 8'h50;

    wr(IDX, 8'h01);
    rd_cr(8'h00, "R5 other index read");
    wr(DAT, 8'hFF);
    wr(IDX, 8'h00);
    rd_cr(8'h50, "R5 other index write ignored");

    wr(KEY, 8'h88);
    rd_cr(8'h00, "R4 locked read");
    wr(DAT, 8'hA0);
    look(10'h1F0, "R4 locked write ignored");
    wr(KEY, 8'h89);
    rd_cr(8'h50, "R4 relock readback");

    do_reset(4'b1010);
    look(10'h1F0, "R1 R6 second reset disk off");
    look(10'h170, "R1 R6 second reset disk off");
    look(10'h3F0, "R1 R8 second reset floppy off");
    look(10'h370, "R1 R8 second reset floppy off");
    rd_cr(8'h00, "R4 reset locks");
    wr(KEY, 8'h89);
    rd_cr(8'hA0, "R1 second strap value");

    @(posedge clk); @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule